// File: doc/BRIEF.md
# Bus-to-Wide-Memory-Port Bridge

This block lets a narrow processor-style bus reach a memory controller whose native port is several times wider. On the bus side it is a classic single-beat Wishbone slave, 32 bits wide with one select bit per byte. On the memory side it drives a 128-bit port built from three independent valid/ready channels: a command channel carrying the native word address and a direction flag, a write-data channel carrying a full native word with a per-byte write mask, and a read-data channel returning a full native word.

Each bus word address maps to one 32-bit lane of a native word. The two low address bits select the lane; the remaining bits form the native address. On a write, the bus data is copied into every lane, and the byte selects are moved into the mask nibble of the chosen lane, so only the addressed bytes change. On a read, the chosen lane of the returned native word is given back on the bus. The bridge waits as long as the memory side needs, without any timeout, and acknowledges once per request with a single-cycle pulse.

Top module: `wb_wide_bridge`

## Requirements
- R1: After a synchronous reset, wb_ack, cmd_valid, wd_valid and rd_ready are all low.
- R2: For an accepted request (wb_cyc and wb_stb high while the bridge is idle), cmd_valid rises with cmd_addr equal to wb_adr shifted right by 2 and cmd_we equal to wb_we.
- R3: On a write, wd_mask equals wb_sel shifted left by 4 times wb_adr[1:0]; bit k of wd_mask enables byte k of wd_data (bits 8k+7 down to 8k).
- R4: On a write, wd_data holds wb_dat_w in each of its four 32-bit lanes.
- R5: On a write, wd_valid is raised only after the command handshake (cmd_valid and cmd_ready both high on a clock edge), and wb_ack is raised in the cycle after the write-data handshake, never earlier.
- R6: On a read, rd_ready is raised after the command handshake, and in the cycle after rd_valid is seen with rd_ready high, wb_ack is high and wb_dat_r equals bits 32*a+31 down to 32*a of rd_data, where a is wb_adr[1:0].
- R7: While wd_ready (on a write) or rd_valid (on a read) stays low, the bridge keeps waiting and wb_ack stays low, for any number of cycles.
- R8: wb_ack is high for exactly one cycle per request, and no new command is issued while wb_stb stays high after that acknowledge; a new request is accepted once wb_stb has dropped.
- R9: Once raised, cmd_valid and wd_valid stay high, with cmd_addr unchanged, until their handshakes complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc | input | 1 | Bus cycle active |
| wb_stb | input | 1 | Bus strobe |
| wb_we | input | 1 | Bus write enable |
| wb_adr | input | ADR_W (30) | Bus word address |
| wb_sel | input | BUS_DW/8 (4) | Bus byte selects |
| wb_dat_w | input | BUS_DW (32) | Bus write data |
| wb_dat_r | output | BUS_DW (32) | Bus read data |
| wb_ack | output | 1 | Bus acknowledge, one-cycle pulse |
| cmd_valid | output | 1 | Native command valid |
| cmd_ready | input | 1 | Native command ready |
| cmd_we | output | 1 | Native command direction, 1 = write |
| cmd_addr | output | ADR_W-2 (28) | Native word address |
| wd_valid | output | 1 | Native write data valid |
| wd_ready | input | 1 | Native write data ready |
| wd_data | output | NAT_DW (128) | Native write data |
| wd_mask | output | NAT_DW/8 (16) | Native byte write mask |
| rd_valid | input | 1 | Native read data valid |
| rd_ready | output | 1 | Native read data ready |
| rd_data | input | NAT_DW (128) | Native read data |

## Verification
A corrupted lane index shows at the first write as a mask nibble in the wrong position on wd_mask, or at the first read as the wrong 32-bit slice on wb_dat_r, in the very cycle the handshake completes. A sequencer state that skips or reorders a step shows up as wd_valid or rd_ready appearing before the command handshake, or as wb_ack arriving while the memory side is still stalled, which the bench sees within one cycle of the skipped step. A state that fails to return to idle, or returns too early, appears as a second acknowledge or a second command while the strobe is still held.

// File: rtl/wb_wide_bridge_pkg.sv
package wb_wide_bridge_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMD   = 3'd1,
    ST_WDATA = 3'd2,
    ST_RDATA = 3'd3,
    ST_ACK   = 3'd4,
    ST_HOLD  = 3'd5
  } bridge_state_t;
endpackage

// File: rtl/bridge_seq.sv
module bridge_seq
  import wb_wide_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic strobe,
  input  logic req_we,
  input  logic cmd_ready,
  input  logic wd_ready,
  input  logic rd_valid,
  output logic capture,
  output logic rd_take,
  output logic cmd_valid,
  output logic wd_valid,
  output logic rd_ready,
  output logic ack
);
  bridge_state_t state, state_nx;
  logic          we_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:  if (req) state_nx = ST_CMD;
      ST_CMD:   if (cmd_ready) state_nx = we_q ? ST_WDATA : ST_RDATA;
      ST_WDATA: if (wd_ready) state_nx = ST_ACK;
      ST_RDATA: if (rd_valid) state_nx = ST_ACK;
      ST_ACK:   state_nx = ST_HOLD;
      ST_HOLD:  if (!strobe) state_nx = ST_IDLE;
      default:  state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      we_q  <= 1'b0;
    end else begin
      state <= state_nx;
      if (capture) we_q <= req_we;
    end
  end

  assign capture   = (state == ST_IDLE) && req;
  assign rd_take   = (state == ST_RDATA) && rd_valid;
  assign cmd_valid = (state == ST_CMD);
  assign wd_valid  = (state == ST_WDATA);
  assign rd_ready  = (state == ST_RDATA);
  assign ack       = (state == ST_ACK);
endmodule

// File: rtl/lane_pack.sv
module lane_pack #(
  parameter int BUS_DW = 32,
  parameter int NAT_DW = 128,
  localparam int SEL_W  = BUS_DW / 8,
  localparam int RATIO  = NAT_DW / BUS_DW,
  localparam int LANE_W = $clog2(RATIO),
  localparam int MASK_W = NAT_DW / 8
) (
  input  logic [LANE_W-1:0] lane,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BUS_DW-1:0] din,
  output logic [NAT_DW-1:0] dout,
  output logic [MASK_W-1:0] mask
);
  for (genvar i = 0; i < RATIO; i++) begin : g_lane
    assign dout[i*BUS_DW +: BUS_DW] = din;
    assign mask[i*SEL_W +: SEL_W]   = (lane == LANE_W'(i)) ? sel : '0;
  end
endmodule

// File: rtl/lane_select.sv
module lane_select #(
  parameter int BUS_DW = 32,
  parameter int NAT_DW = 128,
  localparam int RATIO  = NAT_DW / BUS_DW,
  localparam int LANE_W = $clog2(RATIO)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic [LANE_W-1:0] lane,
  input  logic [NAT_DW-1:0] din,
  output logic [BUS_DW-1:0] dout
);
  logic [BUS_DW-1:0] lanes [RATIO];

  for (genvar i = 0; i < RATIO; i++) begin : g_split
    assign lanes[i] = din[i*BUS_DW +: BUS_DW];
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else if (take) dout <= lanes[lane];
  end
endmodule

// File: rtl/wb_wide_bridge.sv
module wb_wide_bridge #(
  parameter int BUS_DW = 32,
  parameter int NAT_DW = 128,
  parameter int ADR_W  = 30,
  localparam int SEL_W  = BUS_DW / 8,
  localparam int RATIO  = NAT_DW / BUS_DW,
  localparam int LANE_W = $clog2(RATIO),
  localparam int MASK_W = NAT_DW / 8,
  localparam int NADR_W = ADR_W - LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [ADR_W-1:0]  wb_adr,
  input  logic [SEL_W-1:0]  wb_sel,
  input  logic [BUS_DW-1:0] wb_dat_w,
  output logic [BUS_DW-1:0] wb_dat_r,
  output logic              wb_ack,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic              cmd_we,
  output logic [NADR_W-1:0] cmd_addr,
  output logic              wd_valid,
  input  logic              wd_ready,
  output logic [NAT_DW-1:0] wd_data,
  output logic [MASK_W-1:0] wd_mask,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [NAT_DW-1:0] rd_data
);
  logic              capture, rd_take;
  logic [ADR_W-1:0]  adr_q;
  logic [SEL_W-1:0]  sel_q;
  logic [BUS_DW-1:0] dat_q;
  logic              we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      adr_q <= '0;
      sel_q <= '0;
      dat_q <= '0;
      we_q  <= 1'b0;
    end else if (capture) begin
      adr_q <= wb_adr;
      sel_q <= wb_sel;
      dat_q <= wb_dat_w;
      we_q  <= wb_we;
    end
  end

  bridge_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req       (wb_cyc && wb_stb),
    .strobe    (wb_cyc && wb_stb),
    .req_we    (wb_we),
    .cmd_ready (cmd_ready),
    .wd_ready  (wd_ready),
    .rd_valid  (rd_valid),
    .capture   (capture),
    .rd_take   (rd_take),
    .cmd_valid (cmd_valid),
    .wd_valid  (wd_valid),
    .rd_ready  (rd_ready),
    .ack       (wb_ack)
  );

  lane_pack #(.BUS_DW(BUS_DW), .NAT_DW(NAT_DW)) u_pack (
    .lane (adr_q[LANE_W-1:0]),
    .sel  (sel_q),
    .din  (dat_q),
    .dout (wd_data),
    .mask (wd_mask)
  );

  lane_select #(.BUS_DW(BUS_DW), .NAT_DW(NAT_DW)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .take (rd_take),
    .lane (adr_q[LANE_W-1:0]),
    .din  (rd_data),
    .dout (wb_dat_r)
  );

  assign cmd_we   = we_q;
  assign cmd_addr = adr_q[ADR_W-1:LANE_W];
endmodule

// File: rtl/wb_wide_bridge_chk.sv
module wb_wide_bridge_chk #(
  parameter int NAT_DW = 128,
  parameter int NADR_W = 28,
  localparam int MASK_W = NAT_DW / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wb_ack,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [NADR_W-1:0] cmd_addr,
  input logic              wd_valid,
  input logic              wd_ready,
  input logic [MASK_W-1:0] wd_mask,
  input logic              rd_valid,
  input logic              rd_ready
);
  logic [3:0] nib_any;
  always_comb begin
    nib_any = '0;
    for (int i = 0; i < 4; i++) nib_any[i] = |wd_mask[i*(MASK_W/4) +: (MASK_W/4)];
  end

  a_r8_ack_pulse: assert property (@(posedge clk) disable iff (rst)
    wb_ack |=> !wb_ack);

  a_r5_ack_after_handshake: assert property (@(posedge clk) disable iff (rst)
    $rose(wb_ack) |-> $past(wd_valid && wd_ready) || $past(rd_ready && rd_valid));

  a_r9_cmd_hold: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_addr));

  a_r9_wd_hold: assert property (@(posedge clk) disable iff (rst)
    wd_valid && !wd_ready |=> wd_valid);

  a_r3_one_lane: assert property (@(posedge clk) disable iff (rst)
    wd_valid |-> $onehot0(nib_any));

  a_r5_one_phase: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cmd_valid, wd_valid, rd_ready, wb_ack}));

  a_r5_wd_after_cmd: assert property (@(posedge clk) disable iff (rst)
    $rose(wd_valid) |-> $past(cmd_valid && cmd_ready));
endmodule

bind wb_wide_bridge wb_wide_bridge_chk #(.NAT_DW(NAT_DW), .NADR_W(NADR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wb_ack    (wb_ack),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .wd_valid  (wd_valid),
  .wd_ready  (wd_ready),
  .wd_mask   (wd_mask),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready)
);

// File: tb/wb_wide_bridge_bench.sv
module wb_wide_bridge_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wb_cyc = 0, wb_stb = 0, wb_we = 0;
  logic [29:0]  wb_adr = '0;
  logic [3:0]   wb_sel = '0;
  logic [31:0]  wb_dat_w = '0;
  logic [31:0]  wb_dat_r;
  logic         wb_ack;
  logic         cmd_valid, cmd_we;
  logic         cmd_ready = 0;
  logic [27:0]  cmd_addr;
  logic         wd_valid;
  logic         wd_ready = 0;
  logic [127:0] wd_data;
  logic [15:0]  wd_mask;
  logic         rd_valid = 0;
  logic         rd_ready;
  logic [127:0] rd_data = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc_cnt = 0;

  always #10 clk = ~clk;

  wb_wide_bridge u_wb_wide_bridge (.*);

  always @(posedge clk) begin
    cyc_cnt <= cyc_cnt + 1;
    if (cyc_cnt > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog expired: actual %0d cycles expected fewer", cyc_cnt);
      $display("  [TB] %0d tests run, %0d failed", n_chk + 1, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_for(ref logic sig);
    for (int i = 0; i < 50 && !sig; i++) @(negedge clk);
  endtask

  task automatic check_reset();
    @(negedge clk);
    chk(!wb_ack && !cmd_valid && !wd_valid && !rd_ready, "R1 reset outputs",
        {wb_ack, cmd_valid, wd_valid, rd_ready}, 0);
  endtask

  task automatic finish_ack(input logic [31:0] exp_dat, input bit is_rd);
    chk(wb_ack === 1'b1, "R5/R6 ack after data handshake", wb_ack, 1);
    if (is_rd) chk(wb_dat_r === exp_dat, "R6 read lane", wb_dat_r, exp_dat);
    @(negedge clk);
    chk(!wb_ack && !cmd_valid, "R8 single ack, no new cmd while stb held",
        {wb_ack, cmd_valid}, 0);
    @(negedge clk);
    chk(!cmd_valid, "R8 no command before stb drop", cmd_valid, 0);
    wb_stb = 0; wb_cyc = 0;
    @(negedge clk);
  endtask

  task automatic do_write(input logic [29:0] adr, input logic [3:0] sel, input logic [31:0] dat,
                          input int cmd_dly, input int wd_dly);
    logic [15:0] exp_mask;
    exp_mask = 16'(sel) << (4 * adr[1:0]);
    wb_cyc = 1; wb_stb = 1; wb_we = 1; wb_adr = adr; wb_sel = sel; wb_dat_w = dat;
    @(negedge clk);
    wait_for(cmd_valid);
    chk(cmd_valid && cmd_we && cmd_addr == adr[29:2], "R2 write command",
        {cmd_valid, cmd_we, cmd_addr}, {2'b11, adr[29:2]});
    for (int i = 0; i < cmd_dly; i++) begin
      @(negedge clk);
      chk(cmd_valid && !wd_valid && cmd_addr == adr[29:2], "R9/R5 cmd held, no data yet",
          {cmd_valid, wd_valid}, 2'b10);
    end
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
    chk(wd_valid === 1'b1, "R5 write data after cmd", wd_valid, 1);
    chk(wd_mask === exp_mask, "R3 write mask", wd_mask, exp_mask);
    chk(wd_data === {4{dat}}, "R4 replicated data", wd_data, {4{dat}});
    for (int i = 0; i < wd_dly; i++) begin
      @(negedge clk);
      chk(!wb_ack && wd_valid, "R7 stall on write data", {wb_ack, wd_valid}, 2'b01);
    end
    wd_ready = 1;
    @(negedge clk);
    wd_ready = 0;
    finish_ack('0, 0);
  endtask

  task automatic do_read(input logic [29:0] adr, input logic [127:0] word, input int rd_dly);
    logic [31:0] exp_dat;
    exp_dat = word[32*adr[1:0] +: 32];
    wb_cyc = 1; wb_stb = 1; wb_we = 0; wb_adr = adr; wb_sel = 4'hF;
    @(negedge clk);
    wait_for(cmd_valid);
    chk(cmd_valid && !cmd_we && cmd_addr == adr[29:2], "R2 read command",
        {cmd_valid, cmd_we, cmd_addr}, {2'b10, adr[29:2]});
    cmd_ready = 1;
    @(negedge clk);
    cmd_ready = 0;
    chk(rd_ready === 1'b1 && !wd_valid, "R6 read ready after cmd", {rd_ready, wd_valid}, 2'b10);
    for (int i = 0; i < rd_dly; i++) begin
      @(negedge clk);
      chk(!wb_ack && rd_ready, "R7 stall on read data", {wb_ack, rd_ready}, 2'b01);
    end
    rd_data = word; rd_valid = 1;
    @(negedge clk);
    rd_valid = 0; rd_data = '0;
    finish_ack(exp_dat, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    check_reset();
    do_write(30'd0, 4'b0001, 32'h0000_00CA, 0, 0);
    do_write(30'd0, 4'b0010, 32'h0000_00CA, 1, 0);
    do_write(30'd0, 4'b0100, 32'h1234_5678, 0, 2);
    do_write(30'd0, 4'b1000, 32'hDEAD_BEEF, 0, 0);
    do_write(30'd1, 4'b0001, 32'h0000_00CA, 0, 0);
    do_write(30'd2, 4'b0001, 32'h0000_00CA, 2, 3);
    do_write(30'h1234_567, 4'b1011, 32'hA5A5_5A5A, 0, 6);
    do_read(30'd4, 128'hBADDCAFE_FEEDFACE_BEEFCAFE_BAD0DAB0, 0);
    do_read(30'd5, 128'hBADDCAFE_FEEDFACE_BEEFCAFE_BAD0DAB0, 2);
    do_read(30'd6, 128'hBADDCAFE_FEEDFACE_BEEFCAFE_BAD0DAB0, 0);
    do_read(30'h2000_0007, 128'hBADDCAFE_FEEDFACE_BEEFCAFE_BAD0DAB0, 9);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule